// File: doc/BRIEF.md
# Two-Channel Configurable Biquad Cascade Sequencer

This block is the equaliser stage of a stereo audio path. It runs at twice the input sample rate, after a 2x oversampling stage. Each accepted stereo pair goes through a chain of nine second-order section slots. The left channel is processed first, then the right. One multiply-accumulate unit is time-shared across every active slot of both channels. Configuration inputs decide which slots run and whether the two channels share one coefficient set:

- slot 0 is a DC-removing high-pass;
- slots 1 to 4 are user filters;
- slots 5, 6 and 7 are the de-emphasis, bass and treble positions, and can become user filters when the channels are linked;
- slot 8 is a common extra section.

The coefficients live in an internal memory. Software loads them through a simple write port that is open only between sample periods, so a filter never sees a half-updated set. A slot that is switched off passes its input through unchanged and holds its history at zero.

A state machine steps the work through five states:

- `ST_IDLE` waits for a pair and applies coefficient writes.
- `ST_PICK` looks at the current slot.
- `ST_MAC` runs the five taps.
- `ST_STORE` saturates the result and updates the slot history.
- `ST_EMIT` presents the finished pair.

The transitions are:

- IDLE→PICK when a pair is accepted.
- PICK→MAC when the slot is active.
- PICK→PICK when the slot is skipped and work remains.
- PICK→EMIT when the last slot of the right channel is skipped.
- MAC→MAC on taps 0 to 3.
- MAC→STORE after tap 4.
- STORE→PICK when work remains.
- STORE→EMIT after the last slot of the right channel.
- EMIT→IDLE always.

Top module: `eq_cascade_seq`

## Requirements
- R1: A pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only in the idle state and is low from the edge after acceptance until `out_valid` has pulsed. `out_valid` is high for exactly one cycle, and `out_left`/`out_right` hold their values until the next result.
- R2: An active slot computes acc = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2. The data are signed 24-bit and the coefficients are signed 24-bit with 22 fractional bits. The result is acc shifted right arithmetically by 22, then saturated to the range −8388608..8388607.
- R3: The coefficient word address is (set·9 + slot)·5 + tap. The taps are ordered b0, b1, b2, a1, a2. Set 0 serves the left channel and set 1 the right channel. A write to an address of 90 or above has no effect.
- R4: Slot 0 (DC high-pass) runs only when `dc_bypass` is 0.
- R5: Slots 1 to 4 run for channel c only when `dsp_bypass` is 0 and `eq_bypass[c]` is 0. Bit 0 is the left channel and bit 1 the right channel.
- R6: With `link` = 0, `user_hi_en` is ignored. Slot 5 runs iff `deemph_en` is 1, and slots 6 and 7 run for channel c iff `tone_bypass[c]` is 0.
- R7: With `link` = 1, both channels use coefficient set 0. Slot 5+k (k = 0..2) also runs whenever `user_hi_en[k]` is 1.
- R8: Slot 8 runs iff `xover_sel` is 0000 and `drc_en` is 0, and it always uses coefficient set 0.
- R9: An inactive slot passes its input through unchanged and clears its history. When it is re-enabled, it starts from zero history.
- R10: `coef_ready` is high only in the idle state. A write presented while `coef_ready` is low is dropped.
- R11: All configuration inputs are captured when a pair is accepted. Changes made while that pair is in flight do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stereo pair offered |
| in_ready | output | 1 | Engine idle, pair can be taken |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | One-cycle pulse, result pair valid |
| out_left | output | 24 | Left filtered sample, signed |
| out_right | output | 24 | Right filtered sample, signed |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Coefficient word address |
| coef_data | input | 24 | Coefficient value, signed Q2.22 |
| coef_ready | output | 1 | Coefficient writes accepted this cycle |
| link | input | 1 | Channels share coefficient set 0 |
| user_hi_en | input | 3 | Per-slot user enables for slots 5..7 when linked |
| dc_bypass | input | 1 | Skip the DC high-pass slot |
| deemph_en | input | 1 | Run the de-emphasis slot |
| tone_bypass | input | 2 | Per-channel bass/treble bypass |
| eq_bypass | input | 2 | Per-channel user-filter bypass |
| dsp_bypass | input | 1 | Skip all user filters |
| xover_sel | input | 4 | Crossover selection; 0000 frees slot 8 |
| drc_en | input | 1 | Dynamic range control enabled |

## Verification
The bench goes after positive and negative saturation with full-scale samples and coefficients. A design that wraps instead of clamping would flip the sign of the output. It drives coefficient writes while a pair is in flight and writes to out-of-range addresses. A design that leaks either would alias another slot's coefficients or change the next result. It switches slots off and back on across sample periods, and changes the configuration straight after acceptance. A design that keeps stale history or reads live configuration would diverge from the reference model by a decaying echo of an old sample. Linked and unlinked configurations run with distinct left and right coefficient sets. A wrong set selection shows up as a channel using the other channel's filter.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
    localparam int NCH        = 2;
    localparam int NSLOT      = 9;
    localparam int NTAP       = 5;
    localparam int XO_W       = 4;
    localparam int SLOT_DC    = 0;
    localparam int SLOT_USER_LAST = 4;
    localparam int SLOT_DEEMPH = 5;
    localparam int SLOT_BASS   = 6;
    localparam int SLOT_TREBLE = 7;
    localparam int SLOT_COMMON = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_MAC,
        ST_STORE,
        ST_EMIT
    } seq_state_t;
endpackage

// File: rtl/eqc_slot_plan.sv
module eqc_slot_plan
    import eqc_pkg::*;
(
    input  logic                  link,
    input  logic [2:0]            user_hi_en,
    input  logic                  dc_bypass,
    input  logic                  deemph_en,
    input  logic [NCH-1:0]        tone_bypass,
    input  logic [NCH-1:0]        eq_bypass,
    input  logic                  dsp_bypass,
    input  logic [XO_W-1:0]       xover_sel,
    input  logic                  drc_en,
    output logic [NCH*NSLOT-1:0]  run_mask
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R4: DC slot
        assign run_mask[c*NSLOT + SLOT_DC] = !dc_bypass;
        // R5: user slots
        for (genvar s = 1; s <= SLOT_USER_LAST; s++) begin : g_user
            assign run_mask[c*NSLOT + s] = !dsp_bypass && !eq_bypass[c];
        end
        // R6 / R7: fixed-function positions, user-capable when linked
        assign run_mask[c*NSLOT + SLOT_DEEMPH] = deemph_en || (link && user_hi_en[0]);
        assign run_mask[c*NSLOT + SLOT_BASS]   = !tone_bypass[c] || (link && user_hi_en[1]);
        assign run_mask[c*NSLOT + SLOT_TREBLE] = !tone_bypass[c] || (link && user_hi_en[2]);
        // R8: common slot
        assign run_mask[c*NSLOT + SLOT_COMMON] = (xover_sel == '0) && !drc_en;
    end
endmodule

// File: rtl/eqc_mac.sv
module eqc_mac #(
    parameter int DATA_W = 24,
    parameter int COEF_W = 24,
    parameter int ACC_W  = 52,
    parameter int FRAC   = 22
)(
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [DATA_W-1:0] operand,
    input  logic                     subtract,
    output logic signed [ACC_W-1:0]  acc_out,
    output logic signed [DATA_W-1:0] result
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  scaled;

    always_comb begin
        prod     = coef * operand;
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        acc_out  = subtract ? (acc_in - prod_ext) : (acc_in + prod_ext);
        scaled   = acc_in >>> FRAC;
        if (scaled > MAXV)      result = MAXV[DATA_W-1:0];
        else if (scaled < MINV) result = MINV[DATA_W-1:0];
        else                    result = scaled[DATA_W-1:0];
    end
endmodule

// File: rtl/eq_cascade_seq.sv
module eq_cascade_seq
    import eqc_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int COEF_W    = 24,
    parameter int COEF_FRAC = 22,
    parameter int GUARD_W   = 4,
    parameter int ADDR_W    = 7
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    input  logic              coef_wr,
    input  logic [ADDR_W-1:0] coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    output logic              coef_ready,
    input  logic              link,
    input  logic [2:0]        user_hi_en,
    input  logic              dc_bypass,
    input  logic              deemph_en,
    input  logic [NCH-1:0]    tone_bypass,
    input  logic [NCH-1:0]    eq_bypass,
    input  logic              dsp_bypass,
    input  logic [XO_W-1:0]   xover_sel,
    input  logic              drc_en
);
    localparam int ACC_W  = DATA_W + COEF_W + GUARD_W;
    localparam int NWORD  = NCH * NSLOT * NTAP;
    localparam int MASK_W = NCH * NSLOT;
    localparam int MIDX_W = $clog2(MASK_W);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int TAP_W  = $clog2(NTAP);
    localparam int CH_W   = $clog2(NCH);

    seq_state_t state, nxt;

    logic [CH_W-1:0]          ch;
    logic [SLOT_W-1:0]        slot;
    logic [TAP_W-1:0]         tap;
    logic signed [ACC_W-1:0]  acc, acc_nxt;
    logic signed [DATA_W-1:0] cur, held_r, left_res, mac_res, operand, pass_val;
    logic [MASK_W-1:0]        run_mask, mask_q;
    logic                     link_q;
    logic [DATA_W-1:0]        out_l_q, out_r_q;

    logic signed [COEF_W-1:0] coef_mem [NWORD];
    logic signed [DATA_W-1:0] hx1 [NCH][NSLOT];
    logic signed [DATA_W-1:0] hx2 [NCH][NSLOT];
    logic signed [DATA_W-1:0] hy1 [NCH][NSLOT];
    logic signed [DATA_W-1:0] hy2 [NCH][NSLOT];

    logic [MIDX_W-1:0] run_idx;
    logic [ADDR_W-1:0] rd_idx;
    logic [CH_W-1:0]   cset;
    logic              slot_on, last_slot, last_ch, advance, wr_ok;

    eqc_slot_plan u_plan (
        .link        (link),
        .user_hi_en  (user_hi_en),
        .dc_bypass   (dc_bypass),
        .deemph_en   (deemph_en),
        .tone_bypass (tone_bypass),
        .eq_bypass   (eq_bypass),
        .dsp_bypass  (dsp_bypass),
        .xover_sel   (xover_sel),
        .drc_en      (drc_en),
        .run_mask    (run_mask)
    );

    eqc_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(COEF_FRAC)) u_mac (
        .acc_in   (acc),
        .coef     (coef_mem[rd_idx]),
        .operand  (operand),
        .subtract (tap >= TAP_W'(3)),
        .acc_out  (acc_nxt),
        .result   (mac_res)
    );

    always_comb begin
        run_idx   = MIDX_W'(int'(ch) * NSLOT + int'(slot));
        slot_on   = mask_q[run_idx];
        cset      = (link_q || slot == SLOT_W'(SLOT_COMMON)) ? '0 : ch;
        rd_idx    = ADDR_W'((int'(cset) * NSLOT + int'(slot)) * NTAP + int'(tap));
        last_slot = (slot == SLOT_W'(NSLOT-1));
        last_ch   = (ch == CH_W'(NCH-1));
        advance   = (state == ST_STORE) || (state == ST_PICK && !slot_on);
        pass_val  = (state == ST_STORE) ? mac_res : cur;
        wr_ok     = coef_wr && (state == ST_IDLE) && (int'(coef_addr) < NWORD);
        case (tap)
            TAP_W'(0): operand = cur;
            TAP_W'(1): operand = hx1[ch][slot];
            TAP_W'(2): operand = hx2[ch][slot];
            TAP_W'(3): operand = hy1[ch][slot];
            default:   operand = hy2[ch][slot];
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (in_valid) nxt = ST_PICK;
            ST_PICK:  if (slot_on) nxt = ST_MAC;
                      else if (last_slot && last_ch) nxt = ST_EMIT;
            ST_MAC:   if (tap == TAP_W'(NTAP-1)) nxt = ST_STORE;
            ST_STORE: nxt = (last_slot && last_ch) ? ST_EMIT : ST_PICK;
            ST_EMIT:  nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch <= '0; slot <= '0; tap <= '0; acc <= '0;
            cur <= '0; held_r <= '0; left_res <= '0;
            mask_q <= '0; link_q <= 1'b0;
            out_l_q <= '0; out_r_q <= '0;
            for (int i = 0; i < NWORD; i++) coef_mem[i] <= '0;
            for (int c = 0; c < NCH; c++)
                for (int s = 0; s < NSLOT; s++) begin
                    hx1[c][s] <= '0; hx2[c][s] <= '0;
                    hy1[c][s] <= '0; hy2[c][s] <= '0;
                end
        end else begin
            if (wr_ok) coef_mem[coef_addr] <= coef_data;   // R10
            if (state == ST_IDLE && in_valid) begin         // R11 capture
                cur    <= in_left;
                held_r <= in_right;
                ch     <= '0;
                slot   <= '0;
                mask_q <= run_mask;
                link_q <= link;
            end
            if (state == ST_PICK && slot_on) begin
                acc <= '0;
                tap <= '0;
            end
            if (state == ST_PICK && !slot_on) begin          // R9 clear on skip
                hx1[ch][slot] <= '0; hx2[ch][slot] <= '0;
                hy1[ch][slot] <= '0; hy2[ch][slot] <= '0;
            end
            if (state == ST_MAC) begin
                acc <= acc_nxt;
                tap <= tap + TAP_W'(1);
            end
            if (state == ST_STORE) begin
                hx2[ch][slot] <= hx1[ch][slot];
                hx1[ch][slot] <= cur;
                hy2[ch][slot] <= hy1[ch][slot];
                hy1[ch][slot] <= mac_res;
            end
            if (advance) begin
                if (last_slot) begin
                    slot <= '0;
                    if (!last_ch) begin
                        left_res <= pass_val;
                        cur      <= held_r;
                        ch       <= ch + CH_W'(1);
                    end else begin
                        out_l_q <= left_res;
                        out_r_q <= pass_val;
                    end
                end else begin
                    cur  <= pass_val;
                    slot <= slot + SLOT_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        in_ready   = (state == ST_IDLE);
        coef_ready = (state == ST_IDLE);
        out_valid  = (state == ST_EMIT);
        out_left   = out_l_q;
        out_right  = out_r_q;
    end

    a_r1_emit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(mask_q) && $stable(link_q));
    a_r9_skip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PICK && !slot_on) |=>
            (hx1[$past(ch)][$past(slot)] == '0 && hy1[$past(ch)][$past(slot)] == '0));
    a_r2_five_taps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE) |-> ($past(tap) == TAP_W'(NTAP-1)));
endmodule

// File: tb/sim_eq_cascade_seq.sv
module sim_eq_cascade_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [23:0] in_left = '0, in_right = '0;
    logic out_valid;
    logic [23:0] out_left, out_right;
    logic coef_wr = 1'b0;
    logic [6:0] coef_addr = '0;
    logic [23:0] coef_data = '0;
    logic coef_ready;
    logic link = 1'b0;
    logic [2:0] user_hi_en = '0;
    logic dc_bypass = 1'b0, deemph_en = 1'b0, dsp_bypass = 1'b0, drc_en = 1'b0;
    logic [1:0] tone_bypass = '0, eq_bypass = '0;
    logic [3:0] xover_sel = '0;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    int cm [90];
    int mx1 [2][9];
    int mx2 [2][9];
    int my1 [2][9];
    int my2 [2][9];

    always #2 clk = ~clk;

    eq_cascade_seq u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .coef_wr(coef_wr),
        .coef_addr(coef_addr), .coef_data(coef_data), .coef_ready(coef_ready),
        .link(link), .user_hi_en(user_hi_en), .dc_bypass(dc_bypass),
        .deemph_en(deemph_en), .tone_bypass(tone_bypass), .eq_bypass(eq_bypass),
        .dsp_bypass(dsp_bypass), .xover_sel(xover_sel), .drc_en(drc_en)
    );

    task automatic chk(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int sat24(input longint v);
        if (v > 64'sd8388607) return 8388607;
        if (v < -64'sd8388608) return -8388608;
        return int'(v);
    endfunction

    // slot activity from R4..R8
    function automatic bit runs(input int c, input int s);
        if (s == 0) return !dc_bypass;
        if (s <= 4) return !dsp_bypass && !eq_bypass[c];
        if (s == 5) return deemph_en || (link && user_hi_en[0]);
        if (s == 6 || s == 7) return !tone_bypass[c] || (link && user_hi_en[s-5]);
        return (xover_sel == 4'd0) && !drc_en;
    endfunction

    task automatic model(input int l, input int r, output int el, output int er);
        int v;
        for (int c = 0; c < 2; c++) begin
            v = (c == 0) ? l : r;
            for (int s = 0; s < 9; s++) begin
                if (runs(c, s)) begin
                    int base;
                    longint acc;
                    int y;
                    base = (((link || s == 8) ? 0 : c) * 9 + s) * 5;
                    acc = longint'(cm[base]) * v + longint'(cm[base+1]) * mx1[c][s]
                        + longint'(cm[base+2]) * mx2[c][s] - longint'(cm[base+3]) * my1[c][s]
                        - longint'(cm[base+4]) * my2[c][s];
                    y = sat24(acc >>> 22);
                    mx2[c][s] = mx1[c][s]; mx1[c][s] = v;
                    my2[c][s] = my1[c][s]; my1[c][s] = y;
                    v = y;
                end else begin
                    mx1[c][s] = 0; mx2[c][s] = 0; my1[c][s] = 0; my2[c][s] = 0;
                end
            end
            if (c == 0) el = v; else er = v;
        end
    endtask

    task automatic wr_coef(input int addr, input int val);
        @(negedge clk);
        coef_wr = 1'b1; coef_addr = addr[6:0]; coef_data = val[23:0];
        if (coef_ready && addr < 90) cm[addr] = int'($signed(val[23:0]));
        @(negedge clk);
        coef_wr = 1'b0;
    endtask

    function automatic int rnd_coef(input int tap);
        int span;
        span = (tap >= 3) ? (1 << 19) : (1 << 20);
        return int'($urandom_range(0, 2 * span)) - span;
    endfunction

    function automatic int rnd_sample();
        return int'($urandom_range(0, 32'h00FF_FFFF)) - 8388608;
    endfunction

    task automatic load_random();
        for (int a = 0; a < 90; a++) wr_coef(a, rnd_coef(a % 5));
    endtask

    task automatic rnd_cfg(input int force_link);
        link        = (force_link < 0) ? 1'($urandom_range(0, 1)) : 1'(force_link);
        user_hi_en  = 3'($urandom_range(0, 7));
        dc_bypass   = 1'($urandom_range(0, 1));
        deemph_en   = 1'($urandom_range(0, 1));
        dsp_bypass  = 1'($urandom_range(0, 1));
        drc_en      = 1'($urandom_range(0, 1));
        tone_bypass = 2'($urandom_range(0, 3));
        eq_bypass   = 2'($urandom_range(0, 3));
        xover_sel   = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
    endtask

    task automatic only_dc();
        link = 0; user_hi_en = 3'b111; dc_bypass = 0; deemph_en = 0; dsp_bypass = 1;
        drc_en = 1; tone_bypass = 2'b11; eq_bypass = 2'b00; xover_sel = 4'd3;
    endtask

    task automatic run_vec(input string tag, input int l, input int r,
                           input bit flip, input bit busy_wr);
        int el, er, cyc;
        model(l, r, el, er);
        @(negedge clk);
        in_valid = 1'b1; in_left = l[23:0]; in_right = r[23:0];
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 in_ready low while busy", int'(in_ready), 0);
        if (flip) rnd_cfg(-1);
        if (busy_wr) begin
            chk("R10 coef_ready low while busy", int'(coef_ready), 0);
            coef_wr = 1'b1; coef_addr = 7'd0; coef_data = 24'h3FFFFF;
            @(negedge clk);
            coef_wr = 1'b0;
        end
        cyc = 0;
        while (!out_valid && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk({tag, " out_valid seen"}, int'(out_valid), 1);
        chk({tag, " left"}, int'($signed(out_left)), el);
        chk({tag, " right"}, int'($signed(out_right)), er);
        @(negedge clk);
        chk("R1 out_valid single cycle", int'(out_valid), 0);
        chk("R1 output held", int'($signed(out_left)), el);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 90; i++) cm[i] = 0;
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 9; s++) begin
                mx1[c][s] = 0; mx2[c][s] = 0; my1[c][s] = 0; my2[c][s] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset in_ready", int'(in_ready), 1);
        chk("R10 reset coef_ready", int'(coef_ready), 1);
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset out_left", int'(out_left), 0);

        // R3: per-channel sets, out-of-range write ignored
        only_dc();
        wr_coef(0, 1 << 22);
        wr_coef(45, 1 << 21);
        wr_coef(95, 1 << 22);
        run_vec("R3 set select", 1000, 1000, 0, 0);
        run_vec("R3 set select again", -4000, 6000, 0, 0);

        // R2: saturation both ways
        wr_coef(0, 24'h7FFFFF);
        wr_coef(45, 24'h7FFFFF);
        run_vec("R2 saturate", 8388607, -8388608, 0, 0);
        run_vec("R2 saturate swap", -8388608, 8388607, 0, 0);

        load_random();
        // R4: all off -> passthrough
        only_dc(); dc_bypass = 1;
        run_vec("R4 dc bypass passthrough", 12345, -777, 0, 0);
        dc_bypass = 0;
        run_vec("R4 dc active", 12345, -777, 0, 0);
        // R5: per-channel eq bypass
        only_dc(); dsp_bypass = 0; eq_bypass = 2'b01;
        run_vec("R5 left eq bypassed", 300000, 300000, 0, 0);
        eq_bypass = 2'b10;
        run_vec("R5 right eq bypassed", -300000, 250000, 0, 0);
        // R9: toggle common slot
        only_dc(); dc_bypass = 1; drc_en = 0; xover_sel = 4'd0;
        run_vec("R9 common on", 500000, 400000, 0, 0);
        drc_en = 1;
        run_vec("R9 common off passthrough", 500000, 400000, 0, 0);
        drc_en = 0;
        run_vec("R9 common re-enabled zero history", 200000, -100000, 0, 0);
        // R10: busy write dropped
        rnd_cfg(0);
        run_vec("R10 busy write", rnd_sample(), rnd_sample(), 0, 1);
        run_vec("R10 after busy write", rnd_sample(), rnd_sample(), 0, 0);
        // R11: config change in flight
        for (int i = 0; i < 6; i++) begin
            rnd_cfg(-1);
            run_vec("R11 cfg captured", rnd_sample(), rnd_sample(), 1, 0);
        end
        // R6 / R7 / R8 random
        for (int i = 0; i < 30; i++) begin
            rnd_cfg(0);
            run_vec("R6 unlinked", rnd_sample(), rnd_sample(), 0, 0);
        end
        for (int i = 0; i < 30; i++) begin
            rnd_cfg(1);
            run_vec("R7 linked", rnd_sample(), rnd_sample(), 0, 0);
        end
        for (int i = 0; i < 30; i++) begin
            rnd_cfg(-1);
            if (i % 3 == 0) begin xover_sel = 4'd0; drc_en = 0; end
            run_vec("R8 common slot", rnd_sample(), rnd_sample(), 0, 0);
        end
        for (int i = 0; i < 60; i++) begin
            if (i % 10 == 0) load_random();
            rnd_cfg(-1);
            run_vec("R2 mixed", rnd_sample(), rnd_sample(), 0, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule